// File: doc/BRIEF.md
# SAR converter serial output sequencer

This block is the digital core that sits next to the analog part of a 12-bit successive-approximation converter. It runs on the externally supplied data clock. An active-low chip select frames each conversion. After chip select falls, the block spends two falling edges sampling and then drives a low null bit. It then decides one result bit per clock, from the most significant bit down. Each bit appears on the serial output on the same falling edge that decides it, so there is no pipeline delay.

When the last bit has been decided, further clocks replay the word least significant bit first, ending with the most significant bit. The output then locks into high impedance until chip select is raised and lowered again.

A trial code is exported to the analog side, and a comparator input returns the decision. Output enable and output data are separate signals that together stand in for a tri-state pin. A set of state flags shows what the block is doing: sampling, converting, replaying, locked, partly powered down or fully powered down.

States:
- `S_IDLE`: full power-down while chip select is high. With chip select low it is the first half of sampling.
- `S_SAMP`: second half of sampling.
- `S_NULL`: null bit, with the MSB trial on the trial code.
- `S_CONV`: bit decisions.
- `S_REPLAY`: least-significant-first replay.
- `S_LOCK`: output off until chip select cycles.

Transitions, each on a falling data clock edge:
- IDLE→SAMP, SAMP→NULL and NULL→CONV happen unconditionally.
- CONV→REPLAY happens once bit 0 is decided.
- REPLAY→LOCK happens after bit 11 has been shown.
- Any state→IDLE happens at once when chip select goes high or reset is asserted.

Top module: `sar_seq_core`

## Requirements
- R1: While `cs_n` is high, `dout_oe` is 0, `st_full_pd` is 1 and `dac_code` is 0, and data clock edges change nothing.
- R2: On the first falling edge after `cs_n` falls, `st_sampling` stays 1 and `dout_oe` stays 0. On the second falling edge, `dout_oe` becomes 1 with `dout` 0 (the null bit) for one clock period.
- R3: During the null bit, `dac_code` is 0x800. While bit k is being tried, `dac_code` holds the bits already decided above k, bit k set to 1 and all lower bits 0. A bit is kept when `cmp_ge` is 1.
- R4: On the 3rd through 14th falling edges after `cs_n` falls, `dout` shows result bits 11 down to 0, each on the edge that decides it.
- R5: On the 15th through 25th falling edges, `dout` shows bits 1 up to 11. Bit 0 is not repeated.
- R6: From the 26th falling edge on, `dout_oe` is 0 and `st_locked` is 1 until `cs_n` goes high.
- R7: From the decision of bit 0 until `cs_n` goes high, `st_partial_pd` is 1, `st_converting` is 0 and `dac_code` is 0.
- R8: Raising `cs_n` during a conversion drops `dout_oe` and sets `st_full_pd` without waiting for a clock edge. The next falling edge of `cs_n` starts a fresh conversion.
- R9: At most one of `st_sampling`, `st_converting`, `st_replay`, `st_locked` and `st_full_pd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Data clock; state advances on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; high aborts and powers down |
| cmp_ge | input | 1 | Comparator: analog input is at or above the trial code |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Serial data drive enable (0 = high impedance) |
| dac_code | output | 12 | Trial code presented to the comparator model |
| st_sampling | output | 1 | Input sampling in progress |
| st_converting | output | 1 | Null bit or bit decision in progress |
| st_replay | output | 1 | Least-significant-first replay |
| st_locked | output | 1 | Output locked off until chip select cycles |
| st_partial_pd | output | 1 | Analog section powered down after completion |
| st_full_pd | output | 1 | Full power-down (chip select high) |

## Verification
Two things can land in the same clock period: a chip select rise that aborts the conversion, and the falling edge that would decide the next bit. The bench stops checking partway through a conversion and raises chip select two nanoseconds after a rising edge, which is before the falling edge that would decide that bit. One nanosecond later it expects the output disabled and the full power-down flag set. The conversion that follows starts at once. It must produce its own code on every trial code and every serial bit, which shows that none of the aborted decision carried over.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SAMP,
        S_NULL,
        S_CONV,
        S_REPLAY,
        S_LOCK
    } seq_state_e;

endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int NBITS = 12,
    localparam int IW = $clog2(NBITS)
) (
    input  logic          dclk,
    input  logic          clr,
    output seq_state_e    state,
    output logic [IW-1:0] idx
);

    localparam logic [IW-1:0] TOP_IDX = IW'(NBITS - 1);

    seq_state_e    state_nxt;
    logic [IW-1:0] idx_nxt;

    // state register: falling edge, cleared at once by chip select or reset
    always_ff @(negedge dclk or posedge clr) begin
        if (clr) begin
            state <= S_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nxt;
            idx   <= idx_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        unique case (state)
            S_IDLE:   state_nxt = S_SAMP;
            S_SAMP:   state_nxt = S_NULL;
            S_NULL: begin
                state_nxt = S_CONV;
                idx_nxt   = TOP_IDX - 1'b1;
            end
            S_CONV: begin
                if (idx == '0) begin
                    state_nxt = S_REPLAY;
                    idx_nxt   = '0;
                end else begin
                    idx_nxt = idx - 1'b1;
                end
            end
            S_REPLAY: begin
                if (idx == TOP_IDX) begin
                    state_nxt = S_LOCK;
                    idx_nxt   = '0;
                end else begin
                    idx_nxt = idx + 1'b1;
                end
            end
            S_LOCK:   state_nxt = S_LOCK;
            default:  state_nxt = S_IDLE;
        endcase
    end

endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
    import sar_seq_pkg::*;
#(
    parameter int NBITS = 12,
    localparam int IW = $clog2(NBITS)
) (
    input  logic             dclk,
    input  logic             clr,
    input  seq_state_e       state,
    input  logic [IW-1:0]    idx,
    input  logic             cmp_ge,
    output logic             dout,
    output logic             dout_oe,
    output logic [NBITS-1:0] dac_code
);

    localparam int TOP = NBITS - 1;

    logic [NBITS-1:0] res;
    logic [IW:0]      prev_idx;

    // successive-approximation result register
    always_ff @(negedge dclk or posedge clr) begin
        if (clr) begin
            res <= '0;
        end else begin
            unique case (state)
                S_SAMP:  res      <= '0;
                S_NULL:  res[TOP] <= cmp_ge;
                S_CONV:  res[idx] <= cmp_ge;
                default: res      <= res;
            endcase
        end
    end

    assign prev_idx = {1'b0, idx} + 1'b1;

    // output and trial-code selection
    always_comb begin
        dout     = 1'b0;
        dout_oe  = 1'b0;
        dac_code = '0;
        unique case (state)
            S_NULL: begin
                dout_oe       = 1'b1;
                dac_code[TOP] = 1'b1;
            end
            S_CONV: begin
                dout_oe       = 1'b1;
                dout          = res[prev_idx];
                dac_code      = res;
                dac_code[idx] = 1'b1;
            end
            S_REPLAY: begin
                dout_oe = 1'b1;
                dout    = res[idx];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sar_seq_flags.sv
module sar_seq_flags
    import sar_seq_pkg::*;
(
    input  seq_state_e state,
    input  logic       cs_n,
    output logic       st_sampling,
    output logic       st_converting,
    output logic       st_replay,
    output logic       st_locked,
    output logic       st_partial_pd,
    output logic       st_full_pd
);

    always_comb begin
        st_sampling   = 1'b0;
        st_converting = 1'b0;
        st_replay     = 1'b0;
        st_locked     = 1'b0;
        st_partial_pd = 1'b0;
        st_full_pd    = 1'b0;
        unique case (state)
            S_IDLE: begin
                st_full_pd  = cs_n;
                st_sampling = ~cs_n;
            end
            S_SAMP:   st_sampling   = 1'b1;
            S_NULL,
            S_CONV:   st_converting = 1'b1;
            S_REPLAY: begin
                st_replay     = 1'b1;
                st_partial_pd = 1'b1;
            end
            S_LOCK: begin
                st_locked     = 1'b1;
                st_partial_pd = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sar_seq_core.sv
module sar_seq_core
    import sar_seq_pkg::*;
#(
    parameter int NBITS = 12,
    localparam int IW = $clog2(NBITS)
) (
    input  logic             dclk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             cmp_ge,
    output logic             dout,
    output logic             dout_oe,
    output logic [NBITS-1:0] dac_code,
    output logic             st_sampling,
    output logic             st_converting,
    output logic             st_replay,
    output logic             st_locked,
    output logic             st_partial_pd,
    output logic             st_full_pd
);

    logic          clr;
    seq_state_e    state;
    logic [IW-1:0] idx;

    assign clr = ~rst_n | cs_n;

    sar_seq_fsm #(.NBITS(NBITS)) u_fsm (
        .dclk  (dclk),
        .clr   (clr),
        .state (state),
        .idx   (idx)
    );

    sar_seq_dp #(.NBITS(NBITS)) u_dp (
        .dclk     (dclk),
        .clr      (clr),
        .state    (state),
        .idx      (idx),
        .cmp_ge   (cmp_ge),
        .dout     (dout),
        .dout_oe  (dout_oe),
        .dac_code (dac_code)
    );

    sar_seq_flags u_flags (
        .state         (state),
        .cs_n          (cs_n),
        .st_sampling   (st_sampling),
        .st_converting (st_converting),
        .st_replay     (st_replay),
        .st_locked     (st_locked),
        .st_partial_pd (st_partial_pd),
        .st_full_pd    (st_full_pd)
    );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int NBITS = 12
) (
    input logic             dclk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             dout,
    input logic             dout_oe,
    input logic [NBITS-1:0] dac_code,
    input logic             st_sampling,
    input logic             st_converting,
    input logic             st_replay,
    input logic             st_locked,
    input logic             st_partial_pd,
    input logic             st_full_pd
);

    a_r1_deselect_quiet: assert property (@(posedge dclk) disable iff (!rst_n)
        cs_n |-> (!dout_oe && st_full_pd && dac_code == '0));

    a_r2_null_low: assert property (@(posedge dclk) disable iff (!rst_n || cs_n)
        $rose(dout_oe) |-> (!dout && st_converting));

    a_r3_trial_present: assert property (@(posedge dclk) disable iff (!rst_n)
        st_converting |-> (dac_code != '0));

    a_r6_lock_sticky: assert property (@(posedge dclk) disable iff (!rst_n || cs_n)
        st_locked |=> (st_locked && !dout_oe));

    a_r7_partial_quiet: assert property (@(posedge dclk) disable iff (!rst_n)
        st_partial_pd |-> (!st_converting && dac_code == '0));

    a_r9_flags_exclusive: assert property (@(posedge dclk) disable iff (!rst_n)
        $onehot0({st_sampling, st_converting, st_replay, st_locked, st_full_pd}));

endmodule

bind sar_seq_core sar_seq_chk #(.NBITS(NBITS)) u_chk (
    .dclk          (dclk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .dout          (dout),
    .dout_oe       (dout_oe),
    .dac_code      (dac_code),
    .st_sampling   (st_sampling),
    .st_converting (st_converting),
    .st_replay     (st_replay),
    .st_locked     (st_locked),
    .st_partial_pd (st_partial_pd),
    .st_full_pd    (st_full_pd)
);

// File: tb/sar_seq_core_tb.sv
`timescale 1ns/1ps
module sar_seq_core_tb;

    typedef struct {
        logic        oe;
        logic        d;
        logic [4:0]  flags;   // {sampling, converting, replay, locked, partial_pd}
        logic [11:0] dac;
        string       tag;
    } exp_item_t;

    logic        dclk = 1'b1;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        cmp_ge;
    logic [11:0] ain = '0;
    logic        dout, dout_oe;
    logic [11:0] dac_code;
    logic        st_sampling, st_converting, st_replay, st_locked, st_partial_pd, st_full_pd;

    int checks = 0;
    int fails  = 0;
    exp_item_t exp_q[$];

    always #10 dclk = ~dclk;

    // ideal analog comparator model
    assign cmp_ge = (ain >= dac_code);

    sar_seq_core u_dut (
        .dclk          (dclk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .cmp_ge        (cmp_ge),
        .dout          (dout),
        .dout_oe       (dout_oe),
        .dac_code      (dac_code),
        .st_sampling   (st_sampling),
        .st_converting (st_converting),
        .st_replay     (st_replay),
        .st_locked     (st_locked),
        .st_partial_pd (st_partial_pd),
        .st_full_pd    (st_full_pd)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // expected pin state after the k-th falling edge since chip select fell
    function automatic exp_item_t exp_at(int k, logic [11:0] v);
        exp_item_t e;
        e.oe = 1'b0; e.d = 1'b0; e.flags = 5'b00000; e.dac = '0; e.tag = "R2";
        if (k == 1) begin
            e.flags = 5'b10000;
        end else if (k == 2) begin
            e.oe = 1'b1; e.flags = 5'b01000; e.dac = 12'h800; e.tag = "R2";
        end else if (k <= 13) begin
            int ti = 13 - k;
            e.oe = 1'b1; e.d = v[14-k]; e.flags = 5'b01000; e.tag = "R4";
            e.dac = (v & ~((12'h1 << (ti + 1)) - 12'h1)) | (12'h1 << ti);
        end else if (k == 14) begin
            e.oe = 1'b1; e.d = v[0]; e.flags = 5'b00101; e.tag = "R4";
        end else if (k <= 25) begin
            e.oe = 1'b1; e.d = v[k-14]; e.flags = 5'b00101; e.tag = "R5";
        end else begin
            e.flags = 5'b00011; e.tag = "R6";
        end
        return e;
    endfunction

    // monitor: compare at rising edges, midway between the design's falling edges
    always @(posedge dclk) begin
        if (exp_q.size() > 0) begin
            exp_item_t e;
            e = exp_q.pop_front();
            chk({e.tag, " oe"}, 32'(dout_oe), 32'(e.oe));
            if (e.oe) chk({e.tag, " dout"}, 32'(dout), 32'(e.d));
            chk("R9 flags", 32'({st_sampling, st_converting, st_replay, st_locked, st_partial_pd}),
                32'(e.flags));
            if (e.flags[0]) chk("R7 dac idle", 32'(dac_code), 32'(e.dac));
            else            chk("R3 trial code", 32'(dac_code), 32'(e.dac));
        end
    end

    // driver: queue expected items, frame a conversion, then deselect
    task automatic run_conv(logic [11:0] v, int n, string end_tag);
        @(posedge dclk);
        #2;
        ain = v;
        for (int k = 1; k <= n; k++) exp_q.push_back(exp_at(k, v));
        cs_n = 1'b0;
        wait (exp_q.size() == 0);
        #2 cs_n = 1'b1;
        #1;
        chk({end_tag, " oe after cs high"}, 32'(dout_oe), 32'h0);
        chk({end_tag, " full pd after cs high"}, 32'(st_full_pd), 32'h1);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: got hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #35;
        chk("R1 reset oe", 32'(dout_oe), 32'h0);
        chk("R1 reset full pd", 32'(st_full_pd), 32'h1);
        rst_n = 1'b1;
        // R1: clocks with chip select high change nothing
        for (int i = 0; i < 4; i++) begin
            @(posedge dclk);
            chk("R1 idle oe", 32'(dout_oe), 32'h0);
            chk("R1 idle flags", 32'({st_full_pd, st_sampling, st_converting, st_locked}), 32'h8);
            chk("R1 idle dac", 32'(dac_code), 32'h0);
        end
        run_conv(12'hA5C, 30, "R6");
        run_conv(12'h000, 28, "R6");
        run_conv(12'hFFF, 28, "R6");
        run_conv(12'h800, 27, "R6");
        run_conv(12'h7FF, 27, "R6");
        // R8: abort in the middle of the bit decisions, then restart
        run_conv(12'h3C1, 8, "R8");
        run_conv(12'h5A5, 30, "R8");
        run_conv(12'h001, 2, "R8");
        run_conv(12'h9E3, 26, "R1");
        repeat (3) @(posedge dclk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule